// File: doc/BRIEF.md
# Banked Shared-Memory Phase Sequencer

This block schedules one warp-wide shared-memory request across a 32-bank storage array. A request carries 32 lane byte addresses and a two-bit access-width code. The sequencer splits the lanes into access phases. The grouping depends on the width: one phase for 4-byte words, two halves for 8-byte words, and four groups of eight lanes for 16-byte words. Within each phase it resolves bank conflicts by replaying the phase, and each pass serves the lowest-numbered pending lanes that can share the banks.

On every busy cycle the block drives a grant mask and the current phase index. A downstream array uses them to perform the accesses. After the last pass the block drops busy and pulses done. An illegal width code is refused with an error pulse, and the block starts no work for it. The block carries no data. It produces only the schedule.

Top module: `smem_phase_seq`

## Requirements
- R1: After reset, busy_o, done_o and err_o are 0 and grant_o is all zeros.
- R2: A request is taken on a clock edge only when req_valid_i is 1 and busy_o is 0. While busy_o is 1, changes on req_valid_i, req_width_i and req_addr_i do not alter the grants, the phase sequence or err_o.
- R3: Width code 0 (4 bytes) runs one phase, index 0, over all 32 lanes. The bank is byte-address bits [6:2].
- R4: Width code 1 (8 bytes) runs phase 0 over lanes 0..15 and then phase 1 over lanes 16..31. Each lane uses the bank pair selected by bits [6:3], and address bits [2:0] are ignored.
- R5: Width code 2 (16 bytes) runs phases 0..3. Phase p covers lanes 8p..8p+7, each lane uses the bank group selected by bits [6:4], and bits [3:0] are ignored.
- R6: Lanes in one phase that select the same bank group with equal address bits [15:7] are granted in the same cycle (broadcast).
- R7: Lanes in one phase that select the same bank group with different bits [15:7] conflict. Each pass grants lanes greedily in ascending order: a lane is granted when it is pending and does not conflict with any lower lane already granted in that pass. Lanes in different phases never conflict.
- R8: A phase repeats until all its lanes are granted, and only then does the next phase start. phase_o never decreases within a request.
- R9: grant_o is nonzero on every busy cycle, is zero whenever busy_o is 0, and holds only lanes of the current phase. The first grant appears in the cycle after acceptance.
- R10: In the cycle after the last grant, busy_o is 0 and done_o is 1 for exactly one cycle.
- R11: Width code 3 is refused. err_o is 1 for one cycle after the edge that sampled it, and busy_o and grant_o stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_width_i | input | 2 | Access width code: 0=4 B, 1=8 B, 2=16 B, 3=illegal |
| req_addr_i | input | 512 | Lane byte addresses, lane l at bits [16l+15:16l] |
| busy_o | output | 1 | Request in progress |
| grant_o | output | 32 | Lanes served this cycle |
| phase_o | output | 2 | Current phase index |
| done_o | output | 1 | One-cycle pulse after the last grant |
| err_o | output | 1 | One-cycle pulse for an illegal width code |

## Verification
The assertions check the following on every cycle: grants appear only while busy and never as an empty set; grants stay inside the current phase's lanes; the phase index only moves forward; done and error pulses occur with busy low; and captured addresses stay stable for the whole request. Other properties only the bench scenarios can show. These are the exact pass-by-pass grant sets of the greedy order, the broadcast merge, the width-dependent bank grouping, and the fact that a request held on the inputs during busy is ignored. The bench reaches them through the full-bank, all-conflict, partial-conflict and single-phase-replay patterns.

// File: rtl/smem_seq_pkg.sv
package smem_seq_pkg;
  typedef enum logic [1:0] {
    ACC_W4   = 2'd0,
    ACC_W8   = 2'd1,
    ACC_W16  = 2'd2,
    ACC_BAD  = 2'd3
  } acc_width_e;
endpackage

// File: rtl/smem_conflict_matrix.sv
module smem_conflict_matrix #(
  parameter int LANES   = 32,
  parameter int AW      = 16,
  parameter int ROW_LSB = 7
) (
  input  logic [LANES*AW-1:0]    addr_i,
  input  logic [1:0]             width_i,
  output logic [LANES*LANES-1:0] conf_o   // bit i*LANES+j: lane i conflicts with lower lane j
);
  for (genvar gi = 0; gi < LANES; gi++) begin : g_row
    for (genvar gj = 0; gj < LANES; gj++) begin : g_col
      if (gj < gi) begin : g_cmp
        logic [AW-1:0]        a, b;
        logic [ROW_LSB-3:0]   grp_a, grp_b;
        assign a     = addr_i[gi*AW +: AW];
        assign b     = addr_i[gj*AW +: AW];
        assign grp_a = a[ROW_LSB-1:2] >> width_i;
        assign grp_b = b[ROW_LSB-1:2] >> width_i;
        assign conf_o[gi*LANES+gj] = (grp_a == grp_b) && (a[AW-1:ROW_LSB] != b[AW-1:ROW_LSB]);
      end else begin : g_none
        assign conf_o[gi*LANES+gj] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/smem_grant_pick.sv
module smem_grant_pick #(
  parameter int LANES = 32
) (
  input  logic [LANES-1:0]       pending_i,
  input  logic [LANES*LANES-1:0] conf_i,
  output logic [LANES-1:0]       grant_o
);
  logic [LANES-1:0] sel;

  // ascending greedy: each lane checks only lanes already chosen below it
  always_comb begin
    sel = '0;
    for (int i = 0; i < LANES; i++) begin
      logic hit;
      hit = 1'b0;
      for (int j = 0; j < i; j++) begin
        if (sel[j] && conf_i[i*LANES+j]) hit = 1'b1;
      end
      sel[i] = pending_i[i] && !hit;
    end
  end

  assign grant_o = sel;
endmodule

// File: rtl/smem_phase_seq.sv
module smem_phase_seq
  import smem_seq_pkg::*;
#(
  parameter int LANES     = 32,
  parameter int AW        = 16,
  parameter int NUM_BANKS = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                req_valid_i,
  input  logic [1:0]          req_width_i,
  input  logic [LANES*AW-1:0] req_addr_i,
  output logic                busy_o,
  output logic [LANES-1:0]    grant_o,
  output logic [1:0]          phase_o,
  output logic                done_o,
  output logic                err_o
);
  localparam int BANK_BITS = $clog2(NUM_BANKS);
  localparam int ROW_LSB   = BANK_BITS + 2;
  localparam int LANE_BITS = $clog2(LANES);

  function automatic logic [LANES-1:0] phase_mask(logic [1:0] w, logic [1:0] p);
    logic [LANES-1:0] m;
    for (int l = 0; l < LANES; l++)
      m[l] = ((l >> (LANE_BITS - int'(w))) == int'(p));
    return m;
  endfunction

  logic                busy_q, done_q, err_q;
  logic [1:0]          phase_q, width_q;
  logic [LANES-1:0]    pending_q, pick, pend_next;
  logic [LANES*AW-1:0] addr_q;
  logic [LANES*LANES-1:0] conf;
  logic [1:0]          last_phase;

  smem_conflict_matrix #(.LANES(LANES), .AW(AW), .ROW_LSB(ROW_LSB)) u_conf (
    .addr_i (addr_q),
    .width_i(width_q),
    .conf_o (conf)
  );

  smem_grant_pick #(.LANES(LANES)) u_pick (
    .pending_i(pending_q),
    .conf_i   (conf),
    .grant_o  (pick)
  );

  assign pend_next  = pending_q & ~pick;
  assign last_phase = 2'((1 << width_q) - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
      phase_q   <= '0;
      width_q   <= '0;
      pending_q <= '0;
      addr_q    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy_q) begin
        if (req_valid_i) begin
          if (req_width_i == ACC_BAD) begin
            err_q <= 1'b1;
          end else begin
            busy_q    <= 1'b1;
            width_q   <= req_width_i;
            addr_q    <= req_addr_i;
            phase_q   <= '0;
            pending_q <= phase_mask(req_width_i, 2'd0);
          end
        end
      end else if (pend_next != '0) begin
        pending_q <= pend_next;
      end else if (phase_q == last_phase) begin
        busy_q    <= 1'b0;
        done_q    <= 1'b1;
        pending_q <= '0;
      end else begin
        phase_q   <= phase_q + 2'd1;
        pending_q <= phase_mask(width_q, phase_q + 2'd1);
      end
    end
  end

  assign busy_o  = busy_q;
  assign grant_o = busy_q ? pick : '0;
  assign phase_o = phase_q;
  assign done_o  = done_q;
  assign err_o   = err_q;

  // R9
  grant_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> grant_o == '0);
  // R9
  grant_progress_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> grant_o != '0);
  // R9
  grant_in_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (grant_o & ~phase_mask(width_q, phase_o)) == '0);
  // R8
  phase_forward_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> phase_o >= $past(phase_o));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o) && !$past(done_o)));
  // R11
  err_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && grant_o == '0));
  // R2
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(addr_q) && $stable(width_q)));
endmodule

// File: tb/sim_smem_phase_seq.sv
module sim_smem_phase_seq;
  localparam int LANES = 32;
  localparam int AW    = 16;

  logic                clk_i = 1'b0;
  logic                rst_ni;
  logic                req_valid_i;
  logic [1:0]          req_width_i;
  logic [LANES*AW-1:0] req_addr_i;
  logic                busy_o, done_o, err_o;
  logic [LANES-1:0]    grant_o;
  logic [1:0]          phase_o;

  int n_chk = 0;
  int n_err = 0;
  int addrs[LANES];
  logic [31:0] exp_g[$];
  int          exp_p[$];

  always #10 clk_i = ~clk_i;

  smem_phase_seq u0 (
    .clk_i, .rst_ni, .req_valid_i, .req_width_i, .req_addr_i,
    .busy_o, .grant_o, .phase_o, .done_o, .err_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_sim();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  function automatic bit model_conf(int a, int b, int w);
    int ga, gb;
    ga = (a >> (2 + w)) % (32 >> w);
    gb = (b >> (2 + w)) % (32 >> w);
    return (ga == gb) && ((a / 128) != (b / 128));
  endfunction

  task automatic build_model(int w);
    int lpp;
    exp_g.delete();
    exp_p.delete();
    lpp = LANES >> w;
    for (int p = 0; p < (1 << w); p++) begin
      logic [31:0] pend;
      pend = '0;
      for (int l = p * lpp; l < (p + 1) * lpp; l++) pend[l] = 1'b1;
      while (pend != 0) begin
        logic [31:0] g;
        g = '0;
        for (int i = 0; i < LANES; i++) begin
          if (pend[i]) begin
            bit ok;
            ok = 1'b1;
            for (int j = 0; j < i; j++)
              if (g[j] && model_conf(addrs[j], addrs[i], w)) ok = 1'b0;
            g[i] = ok;
          end
        end
        exp_g.push_back(g);
        exp_p.push_back(p);
        pend &= ~g;
      end
    end
  endtask

  // called at a negedge; hold keeps an illegal request on the inputs while busy (R2)
  task automatic run_req(int w, bit hold, string tag);
    build_model(w);
    for (int l = 0; l < LANES; l++) req_addr_i[l*AW +: AW] = AW'(addrs[l]);
    req_width_i = 2'(w);
    req_valid_i = 1'b1;
    @(negedge clk_i);
    if (hold) begin
      req_width_i = 2'd3;
      req_addr_i  = ~req_addr_i;
    end else begin
      req_valid_i = 1'b0;
    end
    for (int k = 0; k < exp_g.size(); k++) begin
      chk({tag, " busy R9"}, 32'(busy_o), 32'd1);
      chk({tag, " grant R7"}, grant_o, exp_g[k]);
      chk({tag, " phase R8"}, 32'(phase_o), 32'(exp_p[k]));
      chk({tag, " done R10"}, 32'(done_o), 32'd0);
      chk({tag, " err R2"}, 32'(err_o), 32'd0);
      if (k == exp_g.size() - 1) req_valid_i = 1'b0;
      @(negedge clk_i);
    end
    chk({tag, " end busy R10"}, 32'(busy_o), 32'd0);
    chk({tag, " end done R10"}, 32'(done_o), 32'd1);
    chk({tag, " end grant R9"}, grant_o, 32'd0);
    @(negedge clk_i);
    chk({tag, " done once R10"}, 32'(done_o), 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_err++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    rst_ni      = 1'b0;
    req_valid_i = 1'b0;
    req_width_i = '0;
    req_addr_i  = '0;
    repeat (3) @(negedge clk_i);
    // R1
    chk("reset busy R1", 32'(busy_o), 32'd0);
    chk("reset grant R1", grant_o, 32'd0);
    chk("reset done R1", 32'(done_o), 32'd0);
    chk("reset err R1", 32'(err_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R3: distinct banks, one pass
    for (int l = 0; l < LANES; l++) addrs[l] = l * 4;
    run_req(0, 1'b0, "w4 distinct R3");
    // R6: all lanes one word
    for (int l = 0; l < LANES; l++) addrs[l] = 'h240;
    run_req(0, 1'b0, "w4 broadcast R6");
    // R7: all on bank 0, different rows
    for (int l = 0; l < LANES; l++) addrs[l] = l * 128;
    run_req(0, 1'b0, "w4 full conflict R7");
    // R7: four-way conflict over eight banks
    for (int l = 0; l < LANES; l++) addrs[l] = (l % 8) * 4 + (l / 8) * 128 + (l % 3);
    run_req(0, 1'b0, "w4 partial R7");
    // R4: halves, no cross-phase conflict
    for (int l = 0; l < LANES; l++) addrs[l] = l * 8 + (l % 8);
    run_req(1, 1'b0, "w8 halves R4");
    // R4/R8: replay within each half
    for (int l = 0; l < LANES; l++) addrs[l] = l * 16;
    run_req(1, 1'b0, "w8 replay R4");
    // R5: four phases, one pass each
    for (int l = 0; l < LANES; l++) addrs[l] = l * 16 + (l % 16);
    run_req(2, 1'b0, "w16 phases R5");
    // R5/R8: phase 2 replays eight times
    for (int l = 0; l < LANES; l++) addrs[l] = (l >= 16 && l < 24) ? l * 128 : l * 16;
    run_req(2, 1'b0, "w16 replay R5");
    // R2: inputs held with an illegal code during busy
    for (int l = 0; l < LANES; l++) addrs[l] = (l % 4) * 4 + (l / 4) * 128;
    run_req(0, 1'b1, "w4 hold R2");

    // R11: illegal width code
    req_width_i = 2'd3;
    req_valid_i = 1'b1;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk("bad err R11", 32'(err_o), 32'd1);
    chk("bad busy R11", 32'(busy_o), 32'd0);
    chk("bad grant R11", grant_o, 32'd0);
    @(negedge clk_i);
    chk("bad err once R11", 32'(err_o), 32'd0);
    chk("bad still idle R11", 32'(busy_o), 32'd0);

    finish_sim();
  end
endmodule